// File: doc/BRIEF.md
# CCD Readout Region Tagger

This block sits directly behind the analog front end of an interline CCD camera. It watches the raw readout raster one sample at a time and tells the downstream pipeline what each sample is. A sample can be a horizontal dummy phase, a shielded dark pixel, a light-sensitive buffer pixel, an imaging pixel, or a sample clocked after the last real pixel of its line. Each tagged sample also carries its coordinate inside the effective image area.

By default the raster has 11 dummy shift phases at the start of every line. These are followed by 1084 real columns: 22 dark, 8 buffer, 1024 active, 8 buffer and 22 dark. The frame holds 1064 pixel rows, arranged as 12 dark, 8 buffer, 1024 active, 8 buffer and 12 dark. One dummy readout row sits above them and one below. All of these counts are parameters.

The block also marks the samples that are trustworthy dark reference. These are the centre dark columns, leaving out the outermost dark column on each side, and only in rows of the effective area. It sums those samples over a frame and turns the sum into a per-frame black level for later subtraction. It latches a sticky error when a line ends before all its real pixels have arrived.

Top module: `ccd_region_tagger`

## Requirements
- R1: While reset is held and on the first cycle after it, all outputs are zero, including `out_tag`, `dark_avg`, `dark_avg_vld` and `line_short_err`.
- R2: Within a line, the first HDUM samples are tagged dummy (code 1). Every sample after the last real column is tagged overclock (code 5), however long the line runs.
- R3: Readout rows before and after the pixel rows are tagged dummy (code 1). The DARK_R pixel rows at the top and at the bottom are tagged dark (code 2) in every real column.
- R4: In the remaining rows, dark columns are tagged dark (2). A sample is tagged active (code 4) only when it lies in both an active row and an active column. Every other real pixel is tagged buffer (code 3).
- R5: `out_x` and `out_y` give the 1-based position inside the effective area (buffer plus active, 1..EFF_W by 1..EFF_H). By default the active pixels therefore span 9..1032 on both axes. Both coordinates are 0 for any sample outside that area.
- R6: `out_dark_ref` is 1 only for dark-column samples in effective-area rows, excluding DARK_GUARD columns at the outer edge and the inner edge of each dark band.
- R7: On a valid frame-start sample that follows an earlier frame, `dark_avg` becomes floor(sum of the previous frame's dark-reference samples / NREF), where NREF = 2*(DARK_C-2*DARK_GUARD)*EFF_H. On that same sample `dark_avg_vld` pulses for one cycle. At all other times `dark_avg` holds its value.
- R8: Outputs appear one clock after the sample is presented. When `pix_vld` was low, `out_vld`, `out_tag` (code 0), `out_data`, coordinates and `out_dark_ref` are all 0.
- R9: A line start arriving before the previous line delivered HDUM plus all real-column samples sets `line_short_err`. The flag stays set until reset. Longer lines never set it.
- R10: Cycles with `pix_vld` low do not advance the column or row position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_vld | input | 1 | Sample strobe |
| line_start | input | 1 | Marks the first sample of a line (with pix_vld) |
| frame_start | input | 1 | Marks the first sample of a frame; implies line_start |
| pix_data | input | DW | Raw sample |
| out_vld | output | 1 | Tagged sample valid |
| out_tag | output | 3 | Region code: 0 none, 1 dummy, 2 dark, 3 buffer, 4 active, 5 overclock |
| out_data | output | DW | Sample delayed to line up with its tag |
| out_x | output | XW | Effective-area column, 1-based, 0 outside |
| out_y | output | YW | Effective-area row, 1-based, 0 outside |
| out_dark_ref | output | 1 | Sample belongs to the dark reference |
| dark_avg | output | DW | Last published per-frame dark level |
| dark_avg_vld | output | 1 | One-cycle pulse when dark_avg is updated |
| line_short_err | output | 1 | Sticky short-line flag |

## Verification
The bench targets the band edges, where an off-by-one boundary would move one whole column or row into the wrong class. It checks the outermost and innermost dark columns, which a wrong guard would wrongly admit to the reference sum and so bias the average. It runs lines stretched past their real length, where a wrapping counter would re-tag overclock samples as dummy. It inserts idle gaps mid-line, which a counter advancing on every clock would turn into shifted coordinates. Bright dark-column data is used to expose a reciprocal divider that rounds the wrong way. A truncated line checks that the error flag rises on the following line start and then stays set.

// File: rtl/ccd_tag_pkg.sv
// Shared region codes for the readout tagger.
package ccd_tag_pkg;
    typedef enum logic [2:0] {
        RG_NONE    = 3'd0,
        RG_DUMMY   = 3'd1,
        RG_DARK    = 3'd2,
        RG_BUFFER  = 3'd3,
        RG_ACTIVE  = 3'd4,
        RG_OVERCLK = 3'd5
    } region_e;
endpackage

// File: rtl/ccd_raster_cnt.sv
// Raster position tracker. Gives the column/row position of the sample
// on the inputs this cycle and flags lines cut short.
// Assumes line_start/frame_start are only meaningful together with pix_vld,
// and that frame_start implies a line start.
module ccd_raster_cnt #(
    parameter int HW        = 11,
    parameter int VW        = 11,
    parameter int LINE_REAL = 1095
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_vld,
    input  logic          line_start,
    input  logic          frame_start,
    output logic [HW-1:0] h_pos,
    output logic [VW-1:0] v_pos,
    output logic          short_err
);
    localparam logic [HW-1:0] HMAX = '1;
    localparam logic [VW-1:0] VMAX = '1;

    logic [HW-1:0] hcnt_q;
    logic [VW-1:0] vcnt_q;
    logic          line_seen_q;
    logic          ls;

    // Position of the current sample, derived from markers and counters.
    always_comb begin
        ls    = line_start | frame_start;
        h_pos = ls ? '0 : hcnt_q;
        if (frame_start)
            v_pos = '0;
        else if (ls)
            v_pos = (vcnt_q == VMAX) ? vcnt_q : vcnt_q + VW'(1);
        else
            v_pos = vcnt_q;
    end

    // Advance counters on valid samples only and latch the short-line flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt_q      <= '0;
            vcnt_q      <= '0;
            line_seen_q <= 1'b0;
            short_err   <= 1'b0;
        end else if (pix_vld) begin
            hcnt_q <= (h_pos == HMAX) ? h_pos : h_pos + HW'(1);
            vcnt_q <= v_pos;
            if (ls) begin
                line_seen_q <= 1'b1;
                if (line_seen_q && (hcnt_q < HW'(LINE_REAL)))
                    short_err <= 1'b1;
            end
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(short_err) |-> short_err); // R9

    AST_ROW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && frame_start) |=> (vcnt_q == '0)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |=> $stable(hcnt_q) && $stable(vcnt_q)); // R10
endmodule

// File: rtl/ccd_region_class.sv
// Combinational region classifier. Maps a raster position to a region
// code, a dark-reference flag and effective-area coordinates.
// Assumes positions come from ccd_raster_cnt (column 0 = first dummy phase).
module ccd_region_class
    import ccd_tag_pkg::*;
#(
    parameter int HDUM       = 11,
    parameter int DARK_C     = 22,
    parameter int BUF_N      = 8,
    parameter int ACT_W      = 1024,
    parameter int DUMMY_R    = 1,
    parameter int DARK_R     = 12,
    parameter int ACT_H      = 1024,
    parameter int DARK_GUARD = 1,
    parameter int HW         = 11,
    parameter int VW         = 11,
    parameter int XW         = 11,
    parameter int YW         = 11
) (
    input  logic [HW-1:0] h_pos,
    input  logic [VW-1:0] v_pos,
    output region_e       tag,
    output logic          dark_ref,
    output logic [XW-1:0] img_x,
    output logic [YW-1:0] img_y
);
    localparam int TOT_C = 2 * (DARK_C + BUF_N) + ACT_W;
    localparam int PIX_R = 2 * (DARK_R + BUF_N) + ACT_H;

    int   hc, vr;
    logic hdum, over, vdum, darkc, darkr, effc, effr, actc, actr, centre;

    // Decode column and row bands, then pick the region by priority.
    always_comb begin
        hc     = int'(h_pos) - HDUM;
        vr     = int'(v_pos) - DUMMY_R;
        hdum   = hc < 0;
        over   = hc >= TOT_C;
        vdum   = (vr < 0) || (vr >= PIX_R);
        darkc  = (hc < DARK_C) || (hc >= TOT_C - DARK_C);
        darkr  = (vr < DARK_R) || (vr >= PIX_R - DARK_R);
        effc   = (hc >= DARK_C) && (hc < TOT_C - DARK_C);
        effr   = (vr >= DARK_R) && (vr < PIX_R - DARK_R);
        actc   = (hc >= DARK_C + BUF_N) && (hc < TOT_C - DARK_C - BUF_N);
        actr   = (vr >= DARK_R + BUF_N) && (vr < PIX_R - DARK_R - BUF_N);
        centre = ((hc >= DARK_GUARD) && (hc < DARK_C - DARK_GUARD)) ||
                 ((hc >= TOT_C - DARK_C + DARK_GUARD) && (hc < TOT_C - DARK_GUARD));

        if (over)
            tag = RG_OVERCLK;
        else if (hdum || vdum)
            tag = RG_DUMMY;
        else if (darkc || darkr)
            tag = RG_DARK;
        else if (actc && actr)
            tag = RG_ACTIVE;
        else
            tag = RG_BUFFER;

        dark_ref = !hdum && !over && darkc && centre && effr;

        if (effc && effr) begin
            img_x = XW'(hc - DARK_C + 1);
            img_y = YW'(vr - DARK_R + 1);
        end else begin
            img_x = '0;
            img_y = '0;
        end
    end
endmodule

// File: rtl/ccd_dark_avg.sv
// Per-frame dark level. Sums dark-reference samples and, on the next
// frame start, divides by the fixed reference count: a shift when the
// count is a power of two, otherwise a multiply by a rounded-up reciprocal
// wide enough to give the exact floor.
// Assumes at most NREF reference samples per frame.
module ccd_dark_avg #(
    parameter int DW   = 12,
    parameter int NREF = 41600
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_vld,
    input  logic          frame_start,
    input  logic          dark_ref,
    input  logic [DW-1:0] pix_data,
    output logic [DW-1:0] avg,
    output logic          avg_vld
);
    localparam int  LG    = $clog2(NREF);
    localparam int  SUM_W = DW + $clog2(NREF + 1);
    localparam bit  POW2  = (NREF & (NREF - 1)) == 0;
    localparam int  K     = DW + 2 * LG;
    localparam logic [63:0] RECIP = ((64'd1 << K) + 64'(NREF) - 64'd1) / 64'(NREF);
    localparam int  RW    = K - LG + 2;
    localparam int  PW    = SUM_W + RW;

    logic [SUM_W-1:0] sum_q;
    logic [DW-1:0]    avg_d;
    logic             frame_seen_q;

    generate
        if (POW2) begin : g_shift
            // Power-of-two count: plain shift.
            always_comb avg_d = DW'(sum_q >> LG);
        end else begin : g_recip
            // Other counts: multiply by reciprocal, keep the integer part.
            always_comb avg_d = DW'((PW'(sum_q) * PW'(RECIP)) >> K);
        end
    endgenerate

    // Accumulate reference samples; publish and restart at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q        <= '0;
            avg          <= '0;
            avg_vld      <= 1'b0;
            frame_seen_q <= 1'b0;
        end else begin
            avg_vld <= 1'b0;
            if (pix_vld && frame_start) begin
                if (frame_seen_q) begin
                    avg     <= avg_d;
                    avg_vld <= 1'b1;
                end
                frame_seen_q <= 1'b1;
                sum_q        <= dark_ref ? SUM_W'(pix_data) : '0;
            end else if (pix_vld && dark_ref) begin
                sum_q <= sum_q + SUM_W'(pix_data);
            end
        end
    end

    AST_AVG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !avg_vld |-> $stable(avg)); // R7
endmodule

// File: rtl/ccd_region_tagger.sv
// Top of the readout region tagger. Tracks the raster, classifies each
// valid sample and registers the result with a one-cycle latency; also
// publishes a per-frame dark level and a sticky short-line flag.
// Assumes markers accompany the first sample of a line or frame.
module ccd_region_tagger
    import ccd_tag_pkg::*;
#(
    parameter int DW         = 12,
    parameter int HDUM       = 11,
    parameter int DARK_C     = 22,
    parameter int BUF_N      = 8,
    parameter int ACT_W      = 1024,
    parameter int DUMMY_R    = 1,
    parameter int DARK_R     = 12,
    parameter int ACT_H      = 1024,
    parameter int DARK_GUARD = 1,
    localparam int EFF_W     = ACT_W + 2 * BUF_N,
    localparam int EFF_H     = ACT_H + 2 * BUF_N,
    localparam int XW        = $clog2(EFF_W + 1),
    localparam int YW        = $clog2(EFF_H + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_vld,
    input  logic          line_start,
    input  logic          frame_start,
    input  logic [DW-1:0] pix_data,
    output logic          out_vld,
    output logic [2:0]    out_tag,
    output logic [DW-1:0] out_data,
    output logic [XW-1:0] out_x,
    output logic [YW-1:0] out_y,
    output logic          out_dark_ref,
    output logic [DW-1:0] dark_avg,
    output logic          dark_avg_vld,
    output logic          line_short_err
);
    localparam int TOT_C     = 2 * (DARK_C + BUF_N) + ACT_W;
    localparam int VTOT      = 2 * (DUMMY_R + DARK_R + BUF_N) + ACT_H;
    localparam int LINE_REAL = HDUM + TOT_C;
    localparam int HW        = $clog2(LINE_REAL + 2);
    localparam int VW        = $clog2(VTOT + 2);
    localparam int NREF      = 2 * (DARK_C - 2 * DARK_GUARD) * EFF_H;

    logic [HW-1:0] h_pos;
    logic [VW-1:0] v_pos;
    region_e       tag_c;
    logic          ref_c;
    logic [XW-1:0] x_c;
    logic [YW-1:0] y_c;

    ccd_raster_cnt #(.HW(HW), .VW(VW), .LINE_REAL(LINE_REAL)) u_cnt (
        .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld),
        .line_start(line_start), .frame_start(frame_start),
        .h_pos(h_pos), .v_pos(v_pos), .short_err(line_short_err)
    );

    ccd_region_class #(
        .HDUM(HDUM), .DARK_C(DARK_C), .BUF_N(BUF_N), .ACT_W(ACT_W),
        .DUMMY_R(DUMMY_R), .DARK_R(DARK_R), .ACT_H(ACT_H),
        .DARK_GUARD(DARK_GUARD), .HW(HW), .VW(VW), .XW(XW), .YW(YW)
    ) u_cls (
        .h_pos(h_pos), .v_pos(v_pos), .tag(tag_c), .dark_ref(ref_c),
        .img_x(x_c), .img_y(y_c)
    );

    ccd_dark_avg #(.DW(DW), .NREF(NREF)) u_avg (
        .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .frame_start(frame_start),
        .dark_ref(ref_c), .pix_data(pix_data),
        .avg(dark_avg), .avg_vld(dark_avg_vld)
    );

    // Register the tagged sample; everything reads zero on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld      <= 1'b0;
            out_tag      <= RG_NONE;
            out_data     <= '0;
            out_x        <= '0;
            out_y        <= '0;
            out_dark_ref <= 1'b0;
        end else begin
            out_vld      <= pix_vld;
            out_tag      <= pix_vld ? tag_c : RG_NONE;
            out_data     <= pix_vld ? pix_data : '0;
            out_x        <= pix_vld ? x_c : '0;
            out_y        <= pix_vld ? y_c : '0;
            out_dark_ref <= pix_vld & ref_c;
        end
    end

    AST_IDLE_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_tag == RG_NONE) && !out_dark_ref); // R8

    AST_REF_IN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        out_dark_ref |-> (out_tag == RG_DARK)); // R6

    AST_COORD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tag == RG_DUMMY || out_tag == RG_OVERCLK) |-> (out_x == '0) && (out_y == '0)); // R5

    AST_AVG_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        dark_avg_vld |-> out_vld); // R7
endmodule

// File: tb/sim_ccd_region_tagger.sv
module sim_ccd_region_tagger;
    localparam int HD = 3, DC = 6, BN = 2, AW = 8, DMR = 1, DKR = 2, AH = 8, GD = 1;
    localparam int TC = 24;            // real columns per line
    localparam int NROWS = 18;         // readout rows incl. dummies
    localparam int LREAL = HD + TC;
    localparam int NREF = 96;          // 2 * 4 centre columns * 12 rows

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_vld = 1'b0, line_start = 1'b0, frame_start = 1'b0;
    logic [11:0] pix_data = '0;
    logic out_vld, out_dark_ref, dark_avg_vld, line_short_err;
    logic [2:0] out_tag;
    logic [11:0] out_data, dark_avg;
    logic [3:0] out_x, out_y;

    always #5 clk = ~clk;

    ccd_region_tagger #(.DW(12), .HDUM(HD), .DARK_C(DC), .BUF_N(BN), .ACT_W(AW),
        .DUMMY_R(DMR), .DARK_R(DKR), .ACT_H(AH), .DARK_GUARD(GD)) u0 (
        .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .line_start(line_start),
        .frame_start(frame_start), .pix_data(pix_data), .out_vld(out_vld),
        .out_tag(out_tag), .out_data(out_data), .out_x(out_x), .out_y(out_y),
        .out_dark_ref(out_dark_ref), .dark_avg(dark_avg),
        .dark_avg_vld(dark_avg_vld), .line_short_err(line_short_err));

    int total = 0, bad = 0;
    bit done = 0;

    // reference model state
    int e_vld = 0, e_tag = 0, e_data = 0, e_x = 0, e_y = 0, e_ref = 0;
    int e_avg = 0, e_avgv = 0, e_err = 0;
    int m_cnt = 0, m_row = 0, m_sum = 0;
    bit m_fseen = 0, m_lseen = 0, prev_idle = 0, cur_after_idle = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic string tag_req(input int t);
        case (t)
            1, 5:    return "R2";
            2:       return "R3";
            3, 4:    return "R4";
            default: return "R8";
        endcase
    endfunction

    // column band of a real pixel index: 0 dark, 1 buffer, 2 active
    function automatic int col_band(input int c);
        if (c < 6 || c > 17) return 0;
        if (c < 8 || c > 15) return 1;
        return 2;
    endfunction
    // row band of a pixel row index: 0 dark, 1 buffer, 2 active
    function automatic int row_band(input int r);
        if (r < 2 || r > 13) return 0;
        if (r < 4 || r > 11) return 1;
        return 2;
    endfunction

    task automatic compare();
        string tr;
        tr = cur_after_idle ? "R10" : tag_req(e_tag);
        chk("R8", "vld", out_vld, e_vld);
        chk(tr, "tag", out_tag, e_tag);
        chk("R8", "data", out_data, e_data);
        chk("R5", "x", out_x, e_x);
        chk("R5", "y", out_y, e_y);
        chk("R6", "ref", out_dark_ref, e_ref);
        chk("R7", "avg", dark_avg, e_avg);
        chk("R7", "avg_vld", dark_avg_vld, e_avgv);
        chk("R9", "err", line_short_err, e_err);
    endtask

    task automatic step(input bit v, input bit ls, input bit fs, input int d);
        int c, r;
        @(negedge clk);
        compare();
        pix_vld = v; line_start = ls; frame_start = fs; pix_data = 12'(d);
        cur_after_idle = prev_idle && v;
        prev_idle = !v;
        e_avgv = 0;
        if (!v) begin
            e_vld = 0; e_tag = 0; e_data = 0; e_x = 0; e_y = 0; e_ref = 0;
            return;
        end
        if (fs) begin
            if (m_fseen) begin e_avg = m_sum / NREF; e_avgv = 1; end
            m_sum = 0; m_fseen = 1;
        end
        if (ls || fs) begin
            if (m_lseen && m_cnt < LREAL) e_err = 1;
            m_lseen = 1;
            m_row = fs ? 0 : m_row + 1;
            m_cnt = 0;
        end
        c = m_cnt - HD;
        r = m_row - DMR;
        m_cnt++;
        e_vld = 1; e_data = d & 4095; e_x = 0; e_y = 0; e_ref = 0;
        if (c >= TC) e_tag = 5;
        else if (c < 0 || r < 0 || r >= 16) e_tag = 1;
        else if (col_band(c) == 0 || row_band(r) == 0) e_tag = 2;
        else if (col_band(c) == 2 && row_band(r) == 2) e_tag = 4;
        else e_tag = 3;
        if (c >= 0 && c < TC && r >= 2 && r <= 13) begin
            if (c >= 6 && c <= 17) begin e_x = c - 5; e_y = r - 1; end
            if ((c >= 1 && c <= 4) || (c >= 19 && c <= 22)) begin
                e_ref = 1; m_sum += d & 4095;
            end
        end
    endtask

    task automatic send_line(input bit fs, input int n, input int row, input int pat, input bit gaps);
        for (int k = 0; k < n; k++) begin
            int d;
            d = (pat == 0) ? ((k * 11 + row * 5 + 7) & 4095) : (4095 - k - row);
            step(1, k == 0, fs && k == 0, d);
            if (gaps && (k % 7 == 3)) step(0, 0, 0, 0);
        end
    endtask

    task automatic send_frame(input int pat, input int extra, input bit gaps);
        for (int r = 0; r < NROWS; r++)
            send_line(r == 0, LREAL + 2 + ((r % 3 == 0) ? extra : 0), r, pat, gaps);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "rst vld", out_vld, 0);
        chk("R1", "rst tag", out_tag, 0);
        chk("R1", "rst avg", dark_avg, 0);
        chk("R1", "rst avg_vld", dark_avg_vld, 0);
        chk("R1", "rst err", line_short_err, 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0);
        send_frame(0, 0, 1'b1);        // frame 1, idle gaps (R10)
        send_frame(1, 4, 1'b0);        // frame 2, bright dark columns, long lines (R2)
        send_line(1, 5, 0, 0, 1'b0);   // publishes frame 2 average (R7), line cut short
        send_line(0, LREAL, 1, 0, 1'b0); // line start flags short line (R9)
        send_line(0, LREAL + 1, 2, 0, 1'b0);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog run did not finish got=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule